// File: doc/BRIEF.md
# Code Image Byte Aligner

This block turns a stream of write requests aimed at a byte-addressed program image into single byte writes, each with its target segment and byte address. A request is either a 16-bit instruction word, a single data byte, an explicit align command or a label marker. Each request carries a segment tag: code, EEPROM or RAM. Each segment keeps its own byte pointer.

In the code segment, instruction words must start on even byte addresses. Data bytes may leave the code pointer odd. The block then inserts one zero pad byte, but only when an alignment event occurs. Those events are an incoming instruction word, an align command, a label marker, or a request that switches the segment back to code. The word-granular program counter is reported beside the byte stream.

A sticky flag reports that the code image has grown past its configured size in words. The output is a valid/ready byte-write port. The request side is held off while earlier bytes are still waiting to leave.

Top module: `code_image_aligner`

## Requirements
- R1: An instruction word (req_kind 1) in the code segment (req_seg 0) is written as two bytes: the low byte at an even address, then the high byte at the next address.
- R2: code_pc always equals the code byte pointer divided by two, rounded down; after a word at an even pointer it has advanced by one.
- R3: A word that arrives while the code pointer is odd is preceded by one byte of value 0x00 at that odd address.
- R4: Data bytes (req_kind 0) in the code segment go to consecutive addresses with no padding, so an odd number of them leaves the pointer odd.
- R5: An align command (req_kind 2) or a label marker (req_kind 3) in the code segment writes one 0x00 pad byte if the code pointer is odd, and writes nothing if it is even.
- R6: A request tagged code that follows a request tagged with another segment first performs the same boundary sync as R5.
- R7: EEPROM requests (req_seg 1) are written bytewise at consecutive addresses, a word low byte first. No padding is ever applied, even at an odd address, and align commands and label markers there write nothing.
- R8: RAM requests (req_seg 2 or 3) produce no write, and they leave the code and EEPROM pointers unchanged.
- R9: Each segment keeps its own pointer, so code writes resume at the code address where they left off after other segments were used.
- R10: After reset, all pointers are zero, the code segment is the current segment, wr_valid is 0, req_ready is 1, code_pc is 0 and code_overflow is 0.
- R11: Writing a code byte at a byte address at or beyond twice MAX_WORDS sets code_overflow. The flag stays set until reset.
- R12: While wr_valid is 1 and wr_ready is 0, wr_addr, wr_data and wr_seg hold their values. While bytes of an accepted request are still pending, req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 data byte, 1 instruction word, 2 align, 3 label marker |
| req_seg | input | 2 | 0 code, 1 EEPROM, 2 or 3 RAM |
| req_data | input | 16 | Word, or data byte in bits 7:0 |
| wr_valid | output | 1 | Byte write present |
| wr_ready | input | 1 | Byte write taken |
| wr_seg | output | 2 | Segment of the byte write (0 code, 1 EEPROM) |
| wr_addr | output | ADDR_W | Byte address within the segment |
| wr_data | output | 8 | Byte value |
| code_pc | output | ADDR_W-1 | Word program counter of the code segment |
| code_overflow | output | 1 | Sticky code size overflow |

## Verification
The hardest case to reach is a boundary sync that is triggered only by a change of segment. The code pointer must be left odd by data bytes, then EEPROM and RAM traffic must pass, and then the next code request must produce the pad at the old odd code address. The stimulus builds that history on purpose. The same sequence then runs under wr_ready backpressure, which shows that the pad, low and high bytes leave in order while the request side stays stalled. A small MAX_WORDS lets the overflow boundary be crossed with only a few writes.

// File: rtl/cia_pkg.sv
package cia_pkg;

  typedef enum logic [1:0] {
    SEG_CODE = 2'd0,
    SEG_EEP  = 2'd1,
    SEG_RAM  = 2'd2
  } seg_e;

  typedef enum logic [1:0] {
    K_BYTE  = 2'd0,
    K_WORD  = 2'd1,
    K_ALIGN = 2'd2,
    K_LABEL = 2'd3
  } kind_e;

  localparam int NSEG = 3;
  localparam logic [7:0] PAD_BYTE = 8'h00;

endpackage

// File: rtl/cia_ptr_bank.sv
module cia_ptr_bank #(
  parameter int ADDR_W = 24,
  parameter int NSEG   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSEG-1:0]              inc_en,
  input  logic [NSEG-1:0]              inc_two,
  output logic [NSEG-1:0][ADDR_W-1:0]  ptr_o
);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_d;

    always_comb begin
      ptr_d = ptr_q + (inc_two[g] ? ADDR_W'(2) : ADDR_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (inc_en[g]) begin
        ptr_q <= ptr_d;
      end
    end

    assign ptr_o[g] = ptr_q;
  end

endmodule

// File: rtl/cia_out_stage.sv
module cia_out_stage #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [1:0]        ld_seg,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [1:0]        wr_seg,
  output logic              slot_free
);

  logic valid_q, valid_d;

  assign slot_free = !valid_q || wr_ready;

  always_comb begin
    valid_d = valid_q;
    if (load) begin
      valid_d = 1'b1;
    end else if (wr_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
      wr_seg  <= '0;
    end else if (load) begin
      wr_addr <= ld_addr;
      wr_data <= ld_data;
      wr_seg  <= ld_seg;
    end
  end

  assign wr_valid = valid_q;

endmodule

// File: rtl/cia_seq.sv
module cia_seq
  import cia_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int unsigned MAX_WORDS = 32'h0040_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [1:0]                   req_kind,
  input  logic [1:0]                   req_seg,
  input  logic [15:0]                  req_data,
  input  logic [NSEG-1:0][ADDR_W-1:0]  ptr_i,
  input  logic                         slot_free,
  output logic [NSEG-1:0]              inc_en,
  output logic [NSEG-1:0]              inc_two,
  output logic                         load,
  output logic [ADDR_W-1:0]            ld_addr,
  output logic [7:0]                   ld_data,
  output logic [1:0]                   ld_seg,
  output logic                         overflow
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(64'(MAX_WORDS) * 64'd2);

  logic        pad_q, lo_q, hi_q, pad_d, lo_d, hi_d;
  logic [15:0] dat_q, dat_d;
  seg_e        pseg_q, pseg_d, last_q, last_d;
  logic        ovf_q, ovf_d;

  kind_e k;
  seg_e  s;
  logic  busy, accept, emit, is_cmd, has_lo, has_hi, want_sync;

  always_comb begin
    k = kind_e'(req_kind);
    s = (req_seg == 2'd3) ? SEG_RAM : seg_e'(req_seg);
  end

  assign busy      = pad_q | lo_q | hi_q;
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign emit      = busy && slot_free;
  assign is_cmd    = (k == K_ALIGN) || (k == K_LABEL);
  assign has_lo    = (k == K_BYTE) || (k == K_WORD);
  assign has_hi    = (k == K_WORD);
  assign want_sync = (s == SEG_CODE) &&
                     ((last_q != SEG_CODE) || (k == K_WORD) || is_cmd);

  // Byte selection for the output stage: pad, then low, then high.
  always_comb begin
    ld_addr = ptr_i[int'(pseg_q)];
    ld_seg  = pseg_q;
    load    = emit;
    if (pad_q) begin
      ld_data = PAD_BYTE;
    end else if (lo_q) begin
      ld_data = dat_q[7:0];
    end else begin
      ld_data = dat_q[15:8];
    end
  end

  always_comb begin
    for (int g = 0; g < NSEG; g++) begin
      inc_en[g]  = emit && (int'(pseg_q) == g);
      inc_two[g] = 1'b0;
    end
    if (accept && (s == SEG_RAM) && has_lo) begin
      inc_en[int'(SEG_RAM)]  = 1'b1;
      inc_two[int'(SEG_RAM)] = has_hi;
    end
  end

  always_comb begin
    pad_d  = pad_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    dat_d  = dat_q;
    pseg_d = pseg_q;
    last_d = last_q;
    ovf_d  = ovf_q;
    if (emit) begin
      if (pad_q) begin
        pad_d = 1'b0;
      end else if (lo_q) begin
        lo_d = 1'b0;
      end else begin
        hi_d = 1'b0;
      end
      if ((pseg_q == SEG_CODE) && ({1'b0, ld_addr} >= LIMIT)) begin
        ovf_d = 1'b1;
      end
    end
    if (accept) begin
      last_d = s;
      pseg_d = s;
      dat_d  = req_data;
      if (s != SEG_RAM) begin
        pad_d = want_sync && ptr_i[int'(SEG_CODE)][0];
        lo_d  = has_lo;
        hi_d  = has_hi;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q  <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      dat_q  <= '0;
      pseg_q <= SEG_CODE;
      last_q <= SEG_CODE;
      ovf_q  <= 1'b0;
    end else begin
      pad_q  <= pad_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      dat_q  <= dat_d;
      pseg_q <= pseg_d;
      last_q <= last_d;
      ovf_q  <= ovf_d;
    end
  end

  assign overflow = ovf_q;

endmodule

// File: rtl/code_image_aligner.sv
module code_image_aligner
  import cia_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int unsigned MAX_WORDS = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_seg,
  input  logic [15:0]       req_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [1:0]        wr_seg,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-2:0] code_pc,
  output logic              code_overflow
);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NSEG-1:0][ADDR_W-1:0] ptr;
  logic [NSEG-1:0]             inc_en, inc_two;
  logic                        load, slot_free;
  logic [ADDR_W-1:0]           ld_addr;
  logic [7:0]                  ld_data;
  logic [1:0]                  ld_seg;

  cia_seq #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_seg   (req_seg),
    .req_data  (req_data),
    .ptr_i     (ptr),
    .slot_free (slot_free),
    .inc_en    (inc_en),
    .inc_two   (inc_two),
    .load      (load),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .ld_seg    (ld_seg),
    .overflow  (code_overflow)
  );

  cia_ptr_bank #(.ADDR_W(ADDR_W), .NSEG(NSEG)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .inc_en  (inc_en),
    .inc_two (inc_two),
    .ptr_o   (ptr)
  );

  cia_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .ld_seg    (ld_seg),
    .wr_ready  (wr_ready),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_seg    (wr_seg),
    .slot_free (slot_free)
  );

  assign code_pc = ptr[int'(SEG_CODE)][ADDR_W-1:1];

endmodule

// File: rtl/cia_checker.sv
module cia_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [1:0]        wr_seg,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-2:0] code_pc,
  input logic              code_overflow
);

  logic [ADDR_W:0] after_addr;
  assign after_addr = {1'b0, wr_addr} + 1'b1;

  // R12: a stalled write holds its contents
  p_hold_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                 $stable(wr_data) && $stable(wr_seg)));

  // R8: RAM never appears on the write port
  p_no_ram_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_seg == 2'd0 || wr_seg == 2'd1));

  // R2: the program counter sits just past the code byte being written
  p_pc_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_seg == 2'd0) |-> (code_pc == after_addr[ADDR_W-1:1]));

  // R11: overflow is sticky
  p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    code_overflow |=> code_overflow);

endmodule

bind code_image_aligner cia_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_seg        (wr_seg),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .code_pc       (code_pc),
  .code_overflow (code_overflow)
);

// File: tb/code_image_aligner_tb.sv
`timescale 1ns/1ps
module code_image_aligner_tb;

  localparam int AW = 16;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] req_seg = 2'd0;
  logic [15:0] req_data = 16'h0;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [1:0] wr_seg;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [AW-2:0] code_pc;
  logic code_overflow;

  always #2 clk = ~clk;

  code_image_aligner #(.ADDR_W(AW), .MAX_WORDS(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_seg(req_seg), .req_data(req_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_seg(wr_seg),
    .wr_addr(wr_addr), .wr_data(wr_data), .code_pc(code_pc),
    .code_overflow(code_overflow));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit run = 1'b0;
  bit force_low = 1'b0;
  int pat = 0;

  logic [1:0]    q_seg[$];
  logic [AW-1:0] q_addr[$];
  logic [7:0]    q_data[$];
  string         q_tag[$];

  logic [AW-1:0] b_ptr[3];
  logic [1:0]    b_last = 2'd0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] s, input logic [7:0] d, input string tag);
    q_seg.push_back(s);
    q_addr.push_back(b_ptr[s]);
    q_data.push_back(d);
    q_tag.push_back(tag);
    b_ptr[s] = b_ptr[s] + 1'b1;
  endtask

  // Driver: builds expected bytes from the requirements, then drives the request
  task automatic send(input logic [1:0] kind, input logic [1:0] seg,
                      input logic [15:0] d, input string tag);
    logic [1:0] s;
    s = (seg == 2'd3) ? 2'd2 : seg;
    if (s == 2'd0) begin
      if (((b_last != 2'd0) || kind != 2'd0) && b_ptr[0][0]) push(2'd0, 8'h00, tag);
    end
    if (s != 2'd2) begin
      if (kind == 2'd0 || kind == 2'd1) push(s, d[7:0], tag);
      if (kind == 2'd1) push(s, d[15:8], tag);
    end
    b_last = s;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_seg = seg; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (q_seg.size() == 0 && req_ready && !wr_valid) break;
    end
  endtask

  // Monitor: sets wr_ready, then compares the handshake that the next edge takes
  always @(negedge clk) begin
    if (run) begin
      pat++;
      wr_ready = force_low ? 1'b0 : ((pat % 4) != 3);
      if (wr_valid && wr_ready) begin
        if (q_seg.size() == 0) begin
          check(1'b0, "unexpected write (R5/R7/R8)", {wr_seg, wr_addr, wr_data}, 0);
        end else begin
          check(wr_seg == q_seg[0] && wr_addr == q_addr[0] && wr_data == q_data[0],
                q_tag[0], {wr_seg, wr_addr, wr_data}, {q_seg[0], q_addr[0], q_data[0]});
          void'(q_seg.pop_front()); void'(q_addr.pop_front());
          void'(q_data.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) b_ptr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(wr_valid == 1'b0, "R10 wr_valid", wr_valid, 0);
    check(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
    check(code_pc == 0, "R10 code_pc", code_pc, 0);
    check(code_overflow == 1'b0, "R10 overflow", code_overflow, 0);
    run = 1'b1;

    send(2'd1, 2'd0, 16'h1234, "R1 word at even address");
    drain();
    check(code_pc == 1, "R2 pc after word", code_pc, 1);

    send(2'd0, 2'd0, 16'h00AA, "R4 data byte");
    send(2'd0, 2'd0, 16'h00BB, "R4 data byte");
    send(2'd0, 2'd0, 16'h00CC, "R4 data byte odd count");
    drain();
    check(code_pc == 2, "R2 pc with odd pointer", code_pc, 2);

    send(2'd1, 2'd0, 16'h5678, "R3 pad before word");
    drain();
    check(code_pc == 4, "R2 pc after padded word", code_pc, 4);

    send(2'd2, 2'd0, 16'h0000, "R5 align when even");
    drain();
    check(q_seg.size() == 0, "R5 nothing left after even align", q_seg.size(), 0);

    send(2'd0, 2'd0, 16'h0011, "R4 data byte");
    send(2'd3, 2'd0, 16'h0000, "R5 label marker pad");
    drain();
    check(code_pc == 5, "R5 pc after label pad", code_pc, 5);

    send(2'd0, 2'd0, 16'h0022, "R4 data byte leaves odd");
    send(2'd1, 2'd1, 16'hBEEF, "R7 eeprom word low first");
    send(2'd0, 2'd1, 16'h0033, "R7 eeprom byte");
    send(2'd1, 2'd1, 16'hCAFE, "R7 eeprom word at odd no pad");
    send(2'd2, 2'd1, 16'h0000, "R7 align in eeprom ignored");
    drain();
    check(code_pc == 5, "R9 code pc untouched by eeprom", code_pc, 5);

    send(2'd0, 2'd2, 16'h0055, "R8 ram byte");
    send(2'd1, 2'd3, 16'h6677, "R8 ram word");
    repeat (6) @(negedge clk);
    check(wr_valid == 1'b0, "R8 no write for ram", wr_valid, 0);

    send(2'd0, 2'd0, 16'h0044, "R6 R9 segment switch sync then byte");
    drain();
    check(code_pc == 6, "R6 pc after switch", code_pc, 6);

    force_low = 1'b1;
    fork
      send(2'd1, 2'd0, 16'h9ABC, "R12 word under backpressure");
      begin
        repeat (8) @(negedge clk);
        check(wr_valid == 1'b1, "R12 write held", wr_valid, 1);
        check(req_ready == 1'b0, "R12 input stalled", req_ready, 0);
        force_low = 1'b0;
      end
    join
    drain();
    check(code_overflow == 1'b0, "R11 no overflow at limit-1", code_overflow, 0);

    send(2'd1, 2'd0, 16'hD00D, "R11 word past limit");
    drain();
    check(code_overflow == 1'b1, "R11 overflow set", code_overflow, 1);
    send(2'd1, 2'd1, 16'h0102, "R7 eeprom after overflow");
    drain();
    check(code_overflow == 1'b1, "R11 overflow sticky", code_overflow, 1);
    check(q_seg.size() == 0, "R1 all expected writes seen", q_seg.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule